// File: doc/BRIEF.md
# Periodic Down-Counting Timer

This block is a programmable interval timer for one clock domain. A 32-bit counter steps down toward zero and reloads itself from a 32-bit period value. A 16-bit divider sets how many clock cycles pass between steps. Each time the counter finishes its count at zero, the block records an event flag and can emit a single-cycle interrupt pulse.

Software reaches the timer through a synchronous 16-bit register port with a 3-bit word address. There is no data stream and no handshake. The port accepts a write on every cycle in which `bus_sel` and `bus_wr` are high, so it never applies back-pressure. Read data is a combinational function of `bus_addr`. Each 32-bit quantity appears as two 16-bit halves: the low half sits at the even offset and the high half at the next odd offset.

Top module: `periodic_timer`

## Requirements
- R1: After reset, both period halves read 0xFFFF, the control word reads 0x0000, the divide word reads 0x0000 and `irq_pulse` is low.
- R2: Word offsets are as follows: 0 is counter bits 15:0, 1 is counter bits 31:16, 2 is period bits 15:0, 3 is period bits 31:16, 4 is control, 5 is reserved, 6 is the divide value and 7 is the live prescale count. Writes to offsets 0, 1, 2, 3 and 6 are read back at the same offset.
- R3: While the timer runs, the counter steps down by one only when the prescale count is zero. Zero events are therefore exactly (period+1)×(divide+1) cycles apart.
- R4: A zero event happens when the counter is at zero and a step is due. On that edge the counter reloads from the period and the prescale count reloads from the divide value.
- R5: While control bit 4 (stop) is 1, the counter and the prescale count both hold their values.
- R6: Writing 1 to control bit 5 loads the counter from the period and the prescale count from the divide value on that edge. Bit 5 always reads back as 0.
- R7: Control bit 15 (flag) is set by every zero event, whatever the enable bit holds. Writing 1 to bit 15 clears it. An event in the same cycle as the clear wins.
- R8: `irq_pulse` is high for the one cycle after a zero event, and only when control bit 14 (enable) was 1.
- R9: Offset 5 always reads 0. A write to offset 5 changes no register.
- R10: A write to offset 0 or offset 1 replaces that half of the counter. Counting then continues from the written value.
- R11: Offset 7 reads the live prescale count. A write to offset 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the timer and the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe; qualified by `bus_sel` |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_pulse | output | 1 | Single-cycle interrupt pulse |

## Verification
The periodic function is run with a period of 4 and divide 0, which checks the plain stepping rate. A run with period 3 and divide 2 shows that the divider multiplies the interval and does not add to it. A third run starts from a counter value written by hand, which separates the first interval (the written value) from the following intervals (the period). The divide-2 pattern is run once with the enable bit clear and once with it set. This tells apart flag setting and pulse gating. The stop intervals between runs confirm that both counters freeze.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    OFS_CNT_LO = 3'd0,
    OFS_CNT_HI = 3'd1,
    OFS_PRD_LO = 3'd2,
    OFS_PRD_HI = 3'd3,
    OFS_CTRL   = 3'd4,
    OFS_RSVD   = 3'd5,
    OFS_DIV    = 3'd6,
    OFS_PSC    = 3'd7
  } tmr_ofs_e;

  localparam int CTL_STOP   = 4;
  localparam int CTL_RELOAD = 5;
  localparam int CTL_IE     = 14;
  localparam int CTL_FLAG   = 15;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_val,
  output logic [DIV_W-1:0] psc_cnt,
  output logic             tick
);
  assign tick = run && (psc_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        psc_cnt <= '0;
    else if (load)     psc_cnt <= div_val;
    else if (run) begin
      if (psc_cnt == '0) psc_cnt <= div_val;
      else               psc_cnt <= psc_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                force_ld,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic [2*HALF_W-1:0] period,
  output logic [2*HALF_W-1:0] cnt,
  output logic                zero_ev
);
  localparam int CW = 2 * HALF_W;

  assign zero_ev = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '1;
    else if (force_ld) cnt <= period;
    else if (wr_lo)    cnt[HALF_W-1:0]  <= wdata;
    else if (wr_hi)    cnt[CW-1:HALF_W] <= wdata;
    else if (zero_ev)  cnt <= period;
    else if (tick)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic [2:0]         addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [2*BUS_W-1:0] cnt,
  input  logic [BUS_W-1:0]   psc_cnt,
  input  logic               zero_ev,
  output logic [BUS_W-1:0]   rdata,
  output logic [2*BUS_W-1:0] period,
  output logic [BUS_W-1:0]   div_val,
  output logic               stop,
  output logic               ie,
  output logic               flag,
  output logic               reload_stb,
  output logic               cnt_wr_lo,
  output logic               cnt_wr_hi,
  output logic               irq
);
  localparam int CW = 2 * BUS_W;

  logic wr_en, ctl_wr;
  logic [BUS_W-1:0] ctl_rd;

  assign wr_en      = sel && wr;
  assign ctl_wr     = wr_en && (addr == OFS_CTRL);
  assign reload_stb = ctl_wr && wdata[CTL_RELOAD];
  assign cnt_wr_lo  = wr_en && (addr == OFS_CNT_LO);
  assign cnt_wr_hi  = wr_en && (addr == OFS_CNT_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period  <= '1;
      div_val <= '0;
      stop    <= 1'b0;
      ie      <= 1'b0;
      flag    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= zero_ev && ie;
      if (wr_en && addr == OFS_PRD_LO) period[BUS_W-1:0]  <= wdata;
      if (wr_en && addr == OFS_PRD_HI) period[CW-1:BUS_W] <= wdata;
      if (wr_en && addr == OFS_DIV)    div_val <= wdata;
      if (ctl_wr) begin
        stop <= wdata[CTL_STOP];
        ie   <= wdata[CTL_IE];
      end
      if (zero_ev)                      flag <= 1'b1;
      else if (ctl_wr && wdata[CTL_FLAG]) flag <= 1'b0;
    end
  end

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_STOP] = stop;
    ctl_rd[CTL_IE]   = ie;
    ctl_rd[CTL_FLAG] = flag;
  end

  always_comb begin
    case (tmr_ofs_e'(addr))
      OFS_CNT_LO: rdata = cnt[BUS_W-1:0];
      OFS_CNT_HI: rdata = cnt[CW-1:BUS_W];
      OFS_PRD_LO: rdata = period[BUS_W-1:0];
      OFS_PRD_HI: rdata = period[CW-1:BUS_W];
      OFS_CTRL:   rdata = ctl_rd;
      OFS_DIV:    rdata = div_val;
      OFS_PSC:    rdata = psc_cnt;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_pulse
);
  localparam int CW = 2 * BUS_W;

  logic [CW-1:0]    cnt_w, period_w;
  logic [BUS_W-1:0] div_w, psc_w;
  logic stop_w, ie_w, flag_w, reload_w, wr_lo_w, wr_hi_w, tick_w, zero_w;

  tmr_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt_w), .psc_cnt(psc_w), .zero_ev(zero_w),
    .rdata(bus_rdata), .period(period_w), .div_val(div_w), .stop(stop_w),
    .ie(ie_w), .flag(flag_w), .reload_stb(reload_w), .cnt_wr_lo(wr_lo_w),
    .cnt_wr_hi(wr_hi_w), .irq(irq_pulse)
  );

  tmr_presc #(.DIV_W(BUS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(!stop_w), .load(reload_w),
    .div_val(div_w), .psc_cnt(psc_w), .tick(tick_w)
  );

  tmr_core #(.HALF_W(BUS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .force_ld(reload_w),
    .wr_lo(wr_lo_w), .wr_hi(wr_hi_w), .wdata(bus_wdata),
    .period(period_w), .cnt(cnt_w), .zero_ev(zero_w)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int BUS_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [2:0]         bus_addr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               irq_pulse,
  input logic [2*BUS_W-1:0] cnt,
  input logic [2*BUS_W-1:0] period,
  input logic [BUS_W-1:0]   psc,
  input logic [BUS_W-1:0]   div_val,
  input logic               stop,
  input logic               flag
);
  logic any_wr, rld_wr;
  assign any_wr = bus_sel && bus_wr;
  assign rld_wr = any_wr && (bus_addr == 3'd4) && bus_wdata[5];

  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag); // R8

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop) && !$past(any_wr)) |-> ($stable(cnt) && $stable(psc))); // R5

  AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rld_wr) |-> (cnt == $past(period) && psc == $past(div_val))); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd5) |-> (bus_rdata == '0)); // R9

  AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!stop && psc == '0 && cnt == '0) |-> flag); // R7
endmodule

bind periodic_timer tmr_checker #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_pulse(irq_pulse), .cnt(cnt_w), .period(period_w), .psc(psc_w),
  .div_val(div_w), .stop(stop_w), .flag(flag_w)
);

// File: tb/periodic_timer_bench.sv
module periodic_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int cyc = 0, n_run = 0, n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  periodic_timer u_periodic_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_pulse(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d, output int edge_no);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0; edge_no = cyc;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_to(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  // Scoreboard monitor: every pulse must match the next expected edge (R3, R4, R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (irq) begin
        if (exp_q.size() == 0) check("R8 unexpected pulse", cyc, 0);
        else begin check("R3 pulse edge", cyc, exp_q[0]); void'(exp_q.pop_front()); end
      end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        check("R3 missed pulse", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq low", irq, 0);
    rd_reg(3'd2, d); check("R1 prd lo", d, 16'hFFFF);
    rd_reg(3'd3, d); check("R1 prd hi", d, 16'hFFFF);
    rd_reg(3'd4, d); check("R1 ctrl", d, 16'h0000);
    rd_reg(3'd6, d); check("R1 div", d, 16'h0000);

    // stop, program period 4 / divide 0, force reload
    wr_reg(3'd4, 16'h0010, e);
    wr_reg(3'd2, 16'd4, e); wr_reg(3'd3, 16'd0, e); wr_reg(3'd6, 16'd0, e);
    rd_reg(3'd2, d); check("R2 prd lo rb", d, 16'd4);
    wr_reg(3'd4, 16'h0030, e);
    rd_reg(3'd0, d); check("R6 cnt lo reload", d, 16'd4);
    rd_reg(3'd1, d); check("R6 cnt hi reload", d, 16'd0);
    rd_reg(3'd4, d); check("R6 reload reads 0", d, 16'h0010);
    repeat (5) @(negedge clk);
    rd_reg(3'd0, d); check("R5 frozen while stopped", d, 16'd4);

    // run, enable on: pulses every 5 cycles
    wr_reg(3'd4, 16'h4000, n);
    exp_q.push_back(n + 5); exp_q.push_back(n + 10); exp_q.push_back(n + 15);
    wait_to(n + 16);
    wr_reg(3'd4, 16'h4010, e);
    rd_reg(3'd4, d); check("R7 flag set", d, 16'hC010);
    wr_reg(3'd4, 16'h8010, e);
    rd_reg(3'd4, d); check("R7 flag w1c", d, 16'h0010);

    // period 3, divide 2, enable off: flag only
    wr_reg(3'd2, 16'd3, e); wr_reg(3'd6, 16'd2, e);
    rd_reg(3'd6, d); check("R2 div rb", d, 16'd2);
    wr_reg(3'd4, 16'h0030, e);
    rd_reg(3'd7, d); check("R11 psc live", d, 16'd2);
    wr_reg(3'd7, 16'hFFFF, e);
    rd_reg(3'd7, d); check("R11 psc write ignored", d, 16'd2);
    wr_reg(3'd4, 16'h0000, n);
    wait_to(n + 13);
    rd_reg(3'd4, d); check("R7 flag without enable", d, 16'h8000);

    // same pattern with enable: pulses every 12 cycles
    wr_reg(3'd4, 16'hC010, e);
    wr_reg(3'd4, 16'h4030, e);
    wr_reg(3'd4, 16'h4000, n);
    exp_q.push_back(n + 12); exp_q.push_back(n + 24);
    wait_to(n + 25);
    wr_reg(3'd4, 16'h4010, e);

    // direct counter write, divide 0, period 3
    wr_reg(3'd6, 16'd0, e);
    wr_reg(3'd4, 16'h4030, e);
    wr_reg(3'd0, 16'd2, e); wr_reg(3'd1, 16'd0, e);
    rd_reg(3'd0, d); check("R10 cnt lo written", d, 16'd2);
    rd_reg(3'd1, d); check("R10 cnt hi written", d, 16'd0);
    wr_reg(3'd4, 16'h4000, n);
    exp_q.push_back(n + 3); exp_q.push_back(n + 7);
    wait_to(n + 8);
    wr_reg(3'd4, 16'h0010, e);

    // reserved offset
    wr_reg(3'd5, 16'hFFFF, e);
    rd_reg(3'd5, d); check("R9 reserved reads 0", d, 16'd0);
    rd_reg(3'd4, d); check("R9 ctrl untouched", d, 16'h8010);
    rd_reg(3'd2, d); check("R9 prd untouched", d, 16'd3);

    repeat (4) @(negedge clk);
    check("R4 all pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule